// File: doc/BRIEF.md
# Foldback PWM Switching Timer

This block times one switching phase of a synchronous step-down stage from a fast system clock. Each switching cycle starts by turning the high-side gate on. A peak-current comparator input ends the on-time. After a dead interval the low-side gate takes over until shortly before the next cycle begins. The two gate outputs are registered and never overlap. A programmable dead interval always separates one gate turning off from the other turning on.

The switching period is not fixed. It is computed from a digitised feedback code. When the output sits near zero the period is stretched to a slow foldback rate, which gives the inductor current time to decay. As the feedback code climbs back toward the regulation point, the period shrinks one code step at a time to the nominal value. A new period is taken up only at a cycle boundary. The on-time is bounded below by a minimum pulse and above by a maximum-duty limit. Two overrides exist. A force input holds the low side on and the high side off. An inhibit input turns both gates off, and when it is released a fresh cycle starts.

With the default parameters and a 100 MHz clock, the nominal period is 200 counts (500 kHz) and the foldback period is 1250 counts (80 kHz). The minimum on-time is 15 counts, the dead interval is 2 counts, and the duty limit is 99 %.

Top module: `pwm_foldback_timer`

## Requirements
- R1: While reset is asserted both gates are low. After reset is released, the high-side gate first goes high on the second rising clock edge.
- R2: The feedback code is an unsigned FB_W-bit value, and any code at or above FB_FULL counts as FB_FULL. The cycle period in clocks is NOM_PERIOD + floor((FOLD_PERIOD - NOM_PERIOD) * (FB_FULL - code) / FB_FULL). A code of 0 gives FOLD_PERIOD and FB_FULL gives NOM_PERIOD. The time between successive high-side rising edges equals this period.
- R3: The period of a cycle is taken from the feedback code sampled on the last clock of the previous cycle. A code change in the middle of a cycle leaves that cycle's length unchanged and sets the length of the next one.
- R4: Once it has turned on without an override, the high-side gate stays high for at least MIN_ON clocks, even if the current-trip input is already high.
- R5: The high-side gate is high for N+1 clocks when the current-trip input is first seen high on its N-th high clock, as long as N+1 lies between MIN_ON and the duty limit.
- R6: Without a current trip, the high-side gate is high for exactly the lesser of floor(period * DUTY_PCT / 100) and period - DEAD clocks.
- R7: In an undisturbed cycle the low-side gate rises exactly DEAD clocks after the high-side gate falls. It stays high for period - on_time - 2*DEAD clocks, or not at all when that value is not positive.
- R8: The two gates are never high in the same clock. Each gate rises only after the other has been low for at least DEAD clocks.
- R9: While force-low is high (and inhibit is low), the high-side gate is low from the next clock on. The low-side gate rises DEAD clocks after the high-side gate fell and stays high until force-low clears.
- R10: Inhibit drives both gates low from the next clock on. After it is released, the high-side gate rises on the second edge and starts a full cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_code | input | FB_W | Digitised feedback level |
| cs_trip | input | 1 | Peak-current comparator result, high ends the on-time |
| force_ls | input | 1 | Hold low side on, high side off |
| inhibit | input | 1 | Hold both gates off; release starts a fresh cycle |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |

## Verification
The bench uses a small configuration with a period range of 20 to 60 clocks. It sweeps every feedback code across and beyond the full-scale point, which separates the clamped nominal code from each interpolated step and from the foldback end. For two periods it sweeps the current-trip arrival over every on-clock. This distinguishes a trip held from the start (minimum pulse), a trip inside the legal window (exact width), and no trip at all (duty limit), and it measures the dead gap and the low-side width each time. Separate sequences change the feedback code mid-cycle, apply force-low and inhibit during a high-side pulse, and release them. These tell a boundary-latched period from an immediate one, and an interlocked handover from an overlapping one.

// File: rtl/pwm_fb_pkg.sv
package pwm_fb_pkg;

    localparam int COUNT_W = 16;

    typedef logic [COUNT_W-1:0] count_t;

    // Cycle timer state
    typedef struct packed {
        logic   idle;      // no cycle running (reset or inhibit)
        logic   hs_phase;  // high-side request active
        count_t cnt;       // position inside the current cycle
        count_t period;    // latched length of the current cycle
        count_t max_on;    // latched on-time ceiling
        count_t ls_from;   // first count at which the low side may be requested
    } cycle_state_t;

    // Gate interlock state
    typedef struct packed {
        logic   hs;
        logic   ls;
        count_t hs_off_run;  // clocks the high side has been low, saturating
        count_t ls_off_run;  // clocks the low side has been low, saturating
    } gate_state_t;

endpackage

// File: rtl/pwm_period_calc.sv
module pwm_period_calc
    import pwm_fb_pkg::*;
#(
    parameter int unsigned FB_W        = 8,
    parameter int unsigned NOM_PERIOD  = 200,
    parameter int unsigned FOLD_PERIOD = 1250,
    parameter int unsigned FB_FULL     = 200,
    parameter int unsigned DUTY_PCT    = 99,
    parameter int unsigned DEAD        = 2
) (
    input  logic [FB_W-1:0] fb_code,
    output count_t          period_o,
    output count_t          max_on_o
);

    localparam int unsigned SPAN = FOLD_PERIOD - NOM_PERIOD;

    logic [31:0] clipped;
    logic [31:0] per;
    logic [31:0] duty_lim;
    logic [31:0] gap_lim;

    // Linear interpolation between foldback and nominal period
    always_comb begin
        clipped = 32'(fb_code);
        if (clipped > FB_FULL) begin
            clipped = FB_FULL;
        end
        per      = NOM_PERIOD + (SPAN * (FB_FULL - clipped)) / FB_FULL;
        duty_lim = (per * DUTY_PCT) / 100;
        gap_lim  = per - DEAD;
        period_o = count_t'(per);
        max_on_o = count_t'((duty_lim < gap_lim) ? duty_lim : gap_lim);
    end

endmodule

// File: rtl/pwm_cycle_timer.sv
module pwm_cycle_timer
    import pwm_fb_pkg::*;
#(
    parameter int unsigned FOLD_PERIOD = 1250,
    parameter int unsigned MIN_ON      = 15,
    parameter int unsigned DEAD        = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   inhibit,
    input  logic   force_ls,
    input  logic   cs_trip,
    input  count_t next_period,
    input  count_t next_max_on,
    output logic   hs_req,
    output logic   ls_req
);

    cycle_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (inhibit) begin
            s_d.idle     = 1'b1;
            s_d.hs_phase = 1'b0;
            s_d.cnt      = '0;
        end else if (s_q.idle || (s_q.cnt == s_q.period - 1'b1)) begin
            // cycle boundary: take up the new period
            s_d.idle     = 1'b0;
            s_d.cnt      = '0;
            s_d.period   = next_period;
            s_d.max_on   = next_max_on;
            s_d.hs_phase = !force_ls;
            s_d.ls_from  = count_t'(DEAD);
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.hs_phase &&
                (force_ls ||
                 (s_q.cnt + 1'b1 >= s_q.max_on) ||
                 (cs_trip && (s_q.cnt + 1'b1 >= count_t'(MIN_ON))))) begin
                s_d.hs_phase = 1'b0;
                s_d.ls_from  = s_q.cnt + 1'b1 + count_t'(DEAD);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.idle     <= 1'b1;
            s_q.hs_phase <= 1'b0;
            s_q.cnt      <= '0;
            s_q.period   <= count_t'(FOLD_PERIOD);
            s_q.max_on   <= '0;
            s_q.ls_from  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hs_req = !s_q.idle && s_q.hs_phase;
    assign ls_req = !s_q.idle && !s_q.hs_phase &&
                    (s_q.cnt >= s_q.ls_from) &&
                    (s_q.cnt < s_q.period - count_t'(DEAD));

endmodule

// File: rtl/pwm_gate_interlock.sv
module pwm_gate_interlock
    import pwm_fb_pkg::*;
#(
    parameter int unsigned DEAD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_req,
    input  logic ls_req,
    input  logic force_ls,
    input  logic inhibit,
    output logic hs_gate,
    output logic ls_gate
);

    localparam count_t RUN_SAT = count_t'(DEAD - 1);

    gate_state_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        g_d.hs = hs_req && !force_ls && !inhibit &&
                 !g_q.ls && (g_q.ls_off_run >= RUN_SAT);
        g_d.ls = (ls_req || force_ls) && !inhibit && !g_d.hs &&
                 !g_q.hs && (g_q.hs_off_run >= RUN_SAT);
        g_d.hs_off_run = g_q.hs ? '0 :
                         (g_q.hs_off_run >= RUN_SAT) ? RUN_SAT : g_q.hs_off_run + 1'b1;
        g_d.ls_off_run = g_q.ls ? '0 :
                         (g_q.ls_off_run >= RUN_SAT) ? RUN_SAT : g_q.ls_off_run + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.hs         <= 1'b0;
            g_q.ls         <= 1'b0;
            g_q.hs_off_run <= RUN_SAT;
            g_q.ls_off_run <= RUN_SAT;
        end else begin
            g_q <= g_d;
        end
    end

    assign hs_gate = g_q.hs;
    assign ls_gate = g_q.ls;

endmodule

// File: rtl/pwm_foldback_timer.sv
module pwm_foldback_timer
    import pwm_fb_pkg::*;
#(
    parameter int unsigned FB_W        = 8,
    parameter int unsigned NOM_PERIOD  = 200,
    parameter int unsigned FOLD_PERIOD = 1250,
    parameter int unsigned FB_FULL     = 200,
    parameter int unsigned MIN_ON      = 15,
    parameter int unsigned DEAD        = 2,
    parameter int unsigned DUTY_PCT    = 99
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FB_W-1:0] fb_code,
    input  logic            cs_trip,
    input  logic            force_ls,
    input  logic            inhibit,
    output logic            hs_gate,
    output logic            ls_gate
);

    count_t next_period;
    count_t next_max_on;
    logic   hs_req;
    logic   ls_req;

    pwm_period_calc #(
        .FB_W       (FB_W),
        .NOM_PERIOD (NOM_PERIOD),
        .FOLD_PERIOD(FOLD_PERIOD),
        .FB_FULL    (FB_FULL),
        .DUTY_PCT   (DUTY_PCT),
        .DEAD       (DEAD)
    ) u_period (
        .fb_code (fb_code),
        .period_o(next_period),
        .max_on_o(next_max_on)
    );

    pwm_cycle_timer #(
        .FOLD_PERIOD(FOLD_PERIOD),
        .MIN_ON     (MIN_ON),
        .DEAD       (DEAD)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .inhibit    (inhibit),
        .force_ls   (force_ls),
        .cs_trip    (cs_trip),
        .next_period(next_period),
        .next_max_on(next_max_on),
        .hs_req     (hs_req),
        .ls_req     (ls_req)
    );

    pwm_gate_interlock #(
        .DEAD(DEAD)
    ) u_interlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_req  (hs_req),
        .ls_req  (ls_req),
        .force_ls(force_ls),
        .inhibit (inhibit),
        .hs_gate (hs_gate),
        .ls_gate (ls_gate)
    );

endmodule

// File: rtl/pwm_foldback_timer_chk.sv
module pwm_foldback_timer_chk #(
    parameter int unsigned MIN_ON = 15,
    parameter int unsigned DEAD   = 2
) (
    input logic clk,
    input logic rst_n,
    input logic force_ls,
    input logic inhibit,
    input logic hs_gate,
    input logic ls_gate
);

    logic [15:0] hs_low_run;
    logic [15:0] ls_low_run;
    logic [15:0] hs_high_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_low_run  <= 16'(DEAD);
            ls_low_run  <= 16'(DEAD);
            hs_high_run <= '0;
        end else begin
            hs_low_run  <= hs_gate ? '0 : ((hs_low_run >= 16'(DEAD)) ? hs_low_run : hs_low_run + 1'b1);
            ls_low_run  <= ls_gate ? '0 : ((ls_low_run >= 16'(DEAD)) ? ls_low_run : ls_low_run + 1'b1);
            hs_high_run <= !hs_gate ? '0 : ((hs_high_run == 16'hFFFF) ? hs_high_run : hs_high_run + 1'b1);
        end
    end

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    assert_dead_before_hs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> (ls_low_run >= 16'(DEAD)));

    assert_dead_before_ls_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> (hs_low_run >= 16'(DEAD)));

    assert_min_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hs_gate) && !$past(inhibit) && !$past(force_ls)) |-> (hs_high_run >= 16'(MIN_ON)));

    assert_inhibit_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> (!hs_gate && !ls_gate));

    assert_force_hs_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ls && !inhibit) |=> !hs_gate);

endmodule

bind pwm_foldback_timer pwm_foldback_timer_chk #(
    .MIN_ON(MIN_ON),
    .DEAD  (DEAD)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .force_ls(force_ls),
    .inhibit (inhibit),
    .hs_gate (hs_gate),
    .ls_gate (ls_gate)
);

// File: tb/test_pwm_foldback_timer.sv
module test_pwm_foldback_timer;

    localparam int FB_W = 8;
    localparam int NOM  = 20;
    localparam int FOLD = 60;
    localparam int FULL = 8;
    localparam int MINO = 4;
    localparam int DT   = 2;
    localparam int PCT  = 90;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [FB_W-1:0] fb_code = '0;
    logic            cs_trip = 1'b0;
    logic            force_ls = 1'b0;
    logic            inhibit = 1'b0;
    logic            hs_gate;
    logic            ls_gate;

    int  tests = 0;
    int  fails = 0;
    int  cycles = 0;
    bit  hs_prev = 1'b0;

    always #4 clk = ~clk;

    pwm_foldback_timer #(
        .FB_W(FB_W), .NOM_PERIOD(NOM), .FOLD_PERIOD(FOLD), .FB_FULL(FULL),
        .MIN_ON(MINO), .DEAD(DT), .DUTY_PCT(PCT)
    ) i_pwm_foldback_timer (
        .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .cs_trip(cs_trip),
        .force_ls(force_ls), .inhibit(inhibit), .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    function automatic int exp_period(int code);
        int c;
        c = (code > FULL) ? FULL : code;
        return NOM + ((FOLD - NOM) * (FULL - c)) / FULL;
    endfunction

    function automatic int exp_max_on(int p);
        int a;
        int b;
        a = (p * PCT) / 100;
        b = p - DT;
        return (a < b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        hs_prev = hs_gate;
        @(negedge clk);
        cycles++;
    endtask

    task automatic wait_rise(output int k);
        k = 0;
        forever begin
            tick();
            k++;
            if (hs_gate && !hs_prev) break;
            if (k > 3000) break;
        end
    endtask

    // Called right after a high-side rise; runs to the next rise.
    task automatic run_cycle(input int n_trip, output int hs_w, output int ls_w,
                             output int gap, output int per);
        int n;
        hs_w = 1; ls_w = 0; gap = 0; per = 0; n = 1;
        if (n_trip > 0) cs_trip = (n >= n_trip);
        forever begin
            tick();
            per++;
            if (hs_gate && !hs_prev) break;
            if (per > 3000) break;
            if (hs_gate) begin
                hs_w++;
                n++;
                if (n_trip > 0) cs_trip = (n >= n_trip);
            end else begin
                cs_trip = 1'b0;
                if (ls_gate) ls_w++;
                else if (ls_w == 0) gap++;
            end
        end
    endtask

    task automatic trip_sweep(input int code, input int n_max);
        int p, mo, k, hw, lw, gp, pr, e_on, e_ls;
        string tag;
        fb_code = FB_W'(code);
        p  = exp_period(code);
        mo = exp_max_on(p);
        wait_rise(k);
        wait_rise(k);
        for (int n = 0; n <= n_max; n++) begin
            if (n == 0) cs_trip = 1'b1;
            wait_rise(k);
            run_cycle(n, hw, lw, gp, pr);
            cs_trip = 1'b0;
            e_on = (n + 1 > mo) ? mo : n + 1;
            if (e_on < MINO) e_on = MINO;
            e_ls = p - e_on - 2 * DT;
            if (e_ls < 0) e_ls = 0;
            if (n + 1 <= MINO) tag = "R4 min on-time";
            else if (n + 1 >= mo) tag = "R6 duty limit";
            else tag = "R5 trip width";
            check(hw == e_on, tag, hw, e_on);
            check(lw == e_ls, "R7 low-side width", lw, e_ls);
            check(pr == p, "R2 period with trip", pr, p);
            if (e_ls > 0) check(gp == DT, "R7 dead gap before low side", gp, DT);
        end
    endtask

    initial begin : watchdog
        while (cycles < 150000) @(negedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int k, bad, first_ls;

        // R1: reset state and first pulse
        fb_code = FB_W'(FULL);
        for (int i = 0; i < 5; i++) begin
            tick();
            check(!hs_gate && !ls_gate, "R1 gates low in reset", {hs_gate, ls_gate}, 0);
        end
        rst_n = 1'b1;
        wait_rise(k);
        check(k == 2, "R1 first high-side edge after reset", k, 2);

        // R2: period for every code, including beyond full scale
        for (int c = 0; c <= FULL + 4; c++) begin
            fb_code = FB_W'(c);
            wait_rise(k);
            wait_rise(k);
            check(k == exp_period(c), "R2 period vs feedback code", k, exp_period(c));
        end

        // R3: mid-cycle code change takes effect at the next cycle
        fb_code = FB_W'(FULL);
        wait_rise(k);
        wait_rise(k);
        for (int i = 0; i < 5; i++) tick();
        fb_code = '0;
        wait_rise(k);
        check(k + 5 == NOM, "R3 current cycle unchanged", k + 5, NOM);
        wait_rise(k);
        check(k == FOLD, "R3 next cycle uses new code", k, FOLD);

        // R4 R5 R6 R7: trip sweeps at nominal and foldback periods
        trip_sweep(FULL, NOM);
        trip_sweep(0, FOLD);

        // R9: force low side during a high-side pulse
        fb_code = FB_W'(FULL);
        wait_rise(k);
        wait_rise(k);
        force_ls = 1'b1;
        first_ls = 0;
        bad = 0;
        for (int i = 1; i <= 8; i++) begin
            tick();
            if (i == 1) check(!hs_gate, "R9 high side off next clock", hs_gate, 0);
            if (ls_gate && first_ls == 0) first_ls = i;
            if (hs_gate) bad++;
        end
        check(first_ls == DT + 1, "R9 low side after dead gap", first_ls, DT + 1);
        for (int i = 0; i < 100; i++) begin
            tick();
            if (hs_gate || !ls_gate) bad++;
        end
        check(bad == 0, "R9 held states under force", bad, 0);
        force_ls = 1'b0;
        wait_rise(k);
        check(k <= NOM + 1, "R9 switching resumes", k, NOM);
        wait_rise(k);
        check(k == NOM, "R9 period after release", k, NOM);

        // R10: inhibit during a pulse, then release
        inhibit = 1'b1;
        tick();
        check(!hs_gate && !ls_gate, "R10 gates off next clock", {hs_gate, ls_gate}, 0);
        bad = 0;
        for (int i = 0; i < 100; i++) begin
            tick();
            if (hs_gate || ls_gate) bad++;
        end
        check(bad == 0, "R10 gates held off", bad, 0);
        inhibit = 1'b0;
        wait_rise(k);
        check(k == 2, "R10 restart edge", k, 2);
        wait_rise(k);
        check(k == NOM, "R10 full cycle after restart", k, NOM);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule